// File: doc/BRIEF.md
# Three-Level Mirrored Switching Sequence Generator

This block plays one switching period of a three-level neutral-clamped inverter as a mirrored series of switch states. A command carries a region code and four dwell times in clock cycles. The region code picks four switching vectors V0..V3. V0 is the N-type form of a small vector. Each later vector raises exactly one phase by one level, so V3 is the P-type form of the same small vector. The period runs forward through V0..V3 and then back down to V0. That gives seven segments, and the two halves have the same length. Each segment holds its vector for its dwell time, counted by a cycle counter. The outputs are a level code for each phase and the index of the current segment.

Commands arrive over a valid/ready handshake. Back-pressure rules: `cmd_ready` is high while the block is idle and in the final cycle of a running period. It is low at all other times. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. The source must hold `cmd_valid`, `cmd_region` and `cmd_dwell` steady until that edge. When a command is offered in the final cycle of a period, the next period follows with no idle cycle. A monitor flags any step inside a period that moves more than one phase or more than one level.

Top module: `npc_seq_gen`

## Requirements
- R1: After reset the phase outputs all read O, `seg_idx` is 0, `step_err` is 0 and `cmd_ready` is 1.
- R2: Level codes are N=0, O=1, P=2, and the value 3 never appears. A region code r in 0..35 splits into k=r/6 and p=r%6. k selects the start vector V0, written as phases a,b,c: 0 ONN, 1 OON, 2 NON, 3 NOO, 4 NNO, 5 ONO. p selects the order in which the phases are raised one level each: 0 abc, 1 acb, 2 bac, 3 bca, 4 cab, 5 cba. V1..V3 are the states after each raise.
- R3: The segments 0..6 show V0,V1,V2,V3,V2,V1,V0 for t0,t1,t2,2*t3,t2,t1,t0 cycles. t0..t3 sit in `cmd_dwell`, with t_i at bits [i*DWELL_W +: DWELL_W]. Segment 0 appears in the cycle after the transfer.
- R4: Region and dwell times are captured at the transfer. Input changes during the period have no effect on it.
- R5: `cmd_ready` is high when idle and in the last cycle of a period, and low otherwise. A command taken in that last cycle starts its segment 0 in the next cycle.
- R6: A transferred command with region code 36 or more is dropped. No period starts, and the outputs keep their previous values.
- R7: A segment with zero dwell is never shown. The output moves straight to the next segment that has a nonzero dwell, and `seg_idx` skips the missing index.
- R8: `step_err` is high for exactly those cycles in which a segment change inside a period shows a vector that differs from the previous one in more than one phase or by more than one level. It is never high in the first cycle of a period.
- R9: When a period ends with no new command, the outputs and `seg_idx` hold the last shown segment, and `cmd_ready` stays high.
- R10: A valid-region command whose dwell times are all zero is taken and starts no period. The outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_region | input | 6 | Region code |
| cmd_dwell | input | 4*DWELL_W | Dwell times t3..t0, t0 in the low bits |
| lvl_a | output | 2 | Phase a level code |
| lvl_b | output | 2 | Phase b level code |
| lvl_c | output | 2 | Phase c level code |
| seg_idx | output | 3 | Current segment 0..6 |
| step_err | output | 1 | Illegal step inside a period |

## Verification
The assertions take the command inputs to be known values and hold while `cmd_valid` waits for `cmd_ready`. They do not take dwell times to sum to any fixed half period. The segment-hold and ordering properties rely on a new command arriving only through the handshake, so their windows exclude the cycle after a transfer. The stimulus follows these rules: every command is driven on a falling edge, held through one transfer edge, and then withdrawn. The dwell lines are scrambled only while `cmd_valid` is low.

// File: rtl/npc_seq_pkg.sv
package npc_seq_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_N = 2'd0;
  localparam lvl_t LVL_O = 2'd1;
  localparam lvl_t LVL_P = 2'd2;

  localparam int PHASES   = 3;
  localparam int VECS     = 4;
  localparam int SEGS     = 2 * VECS - 1;
  localparam int ORDERS   = 6;
  localparam int REGIONS  = ORDERS * 6;
  localparam int REGION_W = $clog2(REGIONS);
  localparam int SEG_W    = $clog2(SEGS);

  // index 0 is phase a, 2 is phase c
  typedef logic [PHASES-1:0][1:0] st3_t;

  // mirrored segment to vector map: 0..3 forward, 4..6 back down
  function automatic logic [1:0] vec_of_seg(input logic [SEG_W-1:0] s);
    logic [SEG_W-1:0] m;
    m = (s <= SEG_W'(VECS - 1)) ? s : SEG_W'(SEGS - 1) - s;
    return m[1:0];
  endfunction
endpackage

// File: rtl/npc_vec_lut.sv
module npc_vec_lut
  import npc_seq_pkg::*;
(
  input  logic [REGION_W-1:0]  region_i,
  output st3_t [VECS-1:0]      vec_o,
  output logic                 ok_o
);
  logic [REGION_W-1:0] base, ord;
  logic [1:0]          ph [VECS-1];
  st3_t                s0;

  always_comb begin
    ok_o = (region_i < REGION_W'(REGIONS));
    base = region_i / REGION_W'(ORDERS);
    ord  = region_i % REGION_W'(ORDERS);
    s0   = {PHASES{LVL_N}};
    case (base)
      0: s0[0] = LVL_O;
      1: begin s0[0] = LVL_O; s0[1] = LVL_O; end
      2: s0[1] = LVL_O;
      3: begin s0[1] = LVL_O; s0[2] = LVL_O; end
      4: s0[2] = LVL_O;
      5: begin s0[0] = LVL_O; s0[2] = LVL_O; end
      default: s0 = {PHASES{LVL_O}};
    endcase
    case (ord)
      0: begin ph[0] = 2'd0; ph[1] = 2'd1; ph[2] = 2'd2; end
      1: begin ph[0] = 2'd0; ph[1] = 2'd2; ph[2] = 2'd1; end
      2: begin ph[0] = 2'd1; ph[1] = 2'd0; ph[2] = 2'd2; end
      3: begin ph[0] = 2'd1; ph[1] = 2'd2; ph[2] = 2'd0; end
      4: begin ph[0] = 2'd2; ph[1] = 2'd0; ph[2] = 2'd1; end
      default: begin ph[0] = 2'd2; ph[1] = 2'd1; ph[2] = 2'd0; end
    endcase
  end

  assign vec_o[0] = s0;

  // each later vector raises one phase by one level
  for (genvar v = 1; v < VECS; v++) begin : g_raise
    st3_t nxt;
    always_comb begin
      nxt = vec_o[v-1];
      for (int p = 0; p < PHASES; p++)
        if (ph[v-1] == 2'(p)) nxt[p] = nxt[p] + 2'd1;
    end
    assign vec_o[v] = nxt;
  end
endmodule

// File: rtl/npc_seg_pick.sv
module npc_seg_pick
  import npc_seq_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic              from_start_i,
  input  logic [SEG_W-1:0]  cur_i,
  input  logic [4*DW-1:0]   dwell_i,
  output logic              found_o,
  output logic [SEG_W-1:0]  seg_o,
  output logic [DW:0]       dur_o
);
  // middle segment merges both halves, so its time doubles
  function automatic logic [DW:0] dur_of(input int s, input logic [4*DW-1:0] dw);
    int         idx;
    logic [DW-1:0] t;
    idx = (s < VECS) ? s : (SEGS - 1 - s);
    t   = dw[idx*DW +: DW];
    return (s == VECS - 1) ? {t, 1'b0} : {1'b0, t};
  endfunction

  always_comb begin
    found_o = 1'b0;
    seg_o   = '0;
    dur_o   = '0;
    for (int s = 0; s < SEGS; s++) begin
      if (!found_o && (from_start_i || SEG_W'(s) > cur_i) &&
          dur_of(s, dwell_i) != '0) begin
        found_o = 1'b1;
        seg_o   = SEG_W'(s);
        dur_o   = dur_of(s, dwell_i);
      end
    end
  end
endmodule

// File: rtl/npc_step_mon.sv
module npc_step_mon
  import npc_seq_pkg::*;
(
  input  st3_t prev_i,
  input  st3_t next_i,
  output logic bad_o
);
  int   nchg;
  logic big;

  always_comb begin
    nchg = 0;
    big  = 1'b0;
    for (int p = 0; p < PHASES; p++) begin
      if (prev_i[p] != next_i[p]) nchg = nchg + 1;
      if ((prev_i[p] > next_i[p] ? prev_i[p] - next_i[p]
                                 : next_i[p] - prev_i[p]) > 2'd1)
        big = 1'b1;
    end
    bad_o = (nchg > 1) || big;
  end
endmodule

// File: rtl/npc_seq_gen.sv
module npc_seq_gen
  import npc_seq_pkg::*;
#(
  parameter int DWELL_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [REGION_W-1:0]    cmd_region,
  input  logic [4*DWELL_W-1:0]   cmd_dwell,
  output logic [1:0]             lvl_a,
  output logic [1:0]             lvl_b,
  output logic [1:0]             lvl_c,
  output logic [SEG_W-1:0]       seg_idx,
  output logic                   step_err
);
  localparam int CNT_W = DWELL_W + 1;

  logic                 busy_q;
  logic [SEG_W-1:0]     seg_q;
  logic [CNT_W-1:0]     cnt_q;
  st3_t                 out_q;
  logic                 err_q;
  st3_t [VECS-1:0]      vec_q;
  logic [4*DWELL_W-1:0] dwell_q;

  st3_t [VECS-1:0]      vec_new;
  logic                 rgn_ok;
  logic                 st_found, nx_found;
  logic [SEG_W-1:0]     st_seg, nx_seg;
  logic [CNT_W-1:0]     st_dur, nx_dur;
  st3_t                 nx_vec;
  logic                 nx_bad;
  logic                 last_cycle, take, take_ok;

  npc_vec_lut u_lut (
    .region_i (cmd_region),
    .vec_o    (vec_new),
    .ok_o     (rgn_ok)
  );

  npc_seg_pick #(.DW(DWELL_W)) u_pick_start (
    .from_start_i (1'b1),
    .cur_i        ('0),
    .dwell_i      (cmd_dwell),
    .found_o      (st_found),
    .seg_o        (st_seg),
    .dur_o        (st_dur)
  );

  npc_seg_pick #(.DW(DWELL_W)) u_pick_next (
    .from_start_i (1'b0),
    .cur_i        (seg_q),
    .dwell_i      (dwell_q),
    .found_o      (nx_found),
    .seg_o        (nx_seg),
    .dur_o        (nx_dur)
  );

  assign nx_vec = vec_q[vec_of_seg(nx_seg)];

  npc_step_mon u_mon (
    .prev_i (out_q),
    .next_i (nx_vec),
    .bad_o  (nx_bad)
  );

  assign last_cycle = busy_q && (cnt_q == '0) && !nx_found;
  assign cmd_ready  = !busy_q || last_cycle;
  assign take       = cmd_valid && cmd_ready;
  assign take_ok    = take && rgn_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      seg_q   <= '0;
      cnt_q   <= '0;
      out_q   <= {PHASES{LVL_O}};
      err_q   <= 1'b0;
      vec_q   <= '0;
      dwell_q <= '0;
    end else begin
      err_q <= 1'b0;
      if (take_ok) begin
        vec_q   <= vec_new;
        dwell_q <= cmd_dwell;
        busy_q  <= st_found;
        if (st_found) begin
          seg_q <= st_seg;
          cnt_q <= st_dur - CNT_W'(1);
          out_q <= vec_new[vec_of_seg(st_seg)];
        end
      end else if (busy_q) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end else if (nx_found) begin
          seg_q <= nx_seg;
          cnt_q <= nx_dur - CNT_W'(1);
          out_q <= nx_vec;
          err_q <= nx_bad;
        end else begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  assign lvl_a    = out_q[0];
  assign lvl_b    = out_q[1];
  assign lvl_c    = out_q[2];
  assign seg_idx  = seg_q;
  assign step_err = err_q;
endmodule

// File: rtl/npc_seq_chk.sv
module npc_seq_chk
  import npc_seq_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic [REGION_W-1:0] cmd_region,
  input logic [1:0]          lvl_a,
  input logic [1:0]          lvl_b,
  input logic [1:0]          lvl_c,
  input logic [SEG_W-1:0]    seg_idx,
  input logic                step_err,
  input logic                busy
);
  logic took;
  assign took = cmd_valid && cmd_ready;

  assert_lvl_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_a != 2'd3) && (lvl_b != 2'd3) && (lvl_c != 2'd3));

  assert_seg_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_idx <= SEG_W'(SEGS - 1));

  assert_hold_in_seg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(took) && seg_idx == $past(seg_idx))
      |-> $stable({lvl_a, lvl_b, lvl_c}));

  assert_ready_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cmd_ready);

  assert_bad_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (took && cmd_region >= REGION_W'(REGIONS))
      |=> (!busy && $stable({lvl_a, lvl_b, lvl_c})));

  assert_seg_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(took) && seg_idx != $past(seg_idx))
      |-> seg_idx > $past(seg_idx));

  assert_err_in_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_err |-> (busy && seg_idx != $past(seg_idx)));
endmodule

bind npc_seq_gen npc_seq_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_region (cmd_region),
  .lvl_a      (lvl_a),
  .lvl_b      (lvl_b),
  .lvl_c      (lvl_c),
  .seg_idx    (seg_idx),
  .step_err   (step_err),
  .busy       (busy_q)
);

// File: tb/test_npc_seq_gen.sv
module test_npc_seq_gen;
  localparam int CLK_P = 10;
  localparam int DW    = 10;
  localparam int NTAB  = 9;
  // region, t0, t1, t2, t3
  localparam int TBL [NTAB][5] = '{
    '{0, 3, 2, 2, 1}, '{7, 1, 1, 1, 1}, '{14, 2, 3, 1, 2},
    '{21, 4, 1, 2, 1}, '{28, 1, 2, 3, 3}, '{35, 2, 2, 2, 2},
    '{10, 2, 0, 3, 1}, '{19, 1, 2, 2, 0}, '{3, 0, 2, 2, 2}};

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic cmd_ready;
  logic [5:0] cmd_region = '0;
  logic [4*DW-1:0] cmd_dwell = '0;
  logic [1:0] lvl_a, lvl_b, lvl_c;
  logic [2:0] seg_idx;
  logic step_err;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  npc_seq_gen #(.DWELL_W(DW)) i_npc_seq_gen (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_region(cmd_region), .cmd_dwell(cmd_dwell), .lvl_a(lvl_a),
    .lvl_b(lvl_b), .lvl_c(lvl_c), .seg_idx(seg_idx), .step_err(step_err));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // vector v of region r, packed {c,b,a}, from the R2 rules
  function automatic logic [5:0] ref_vec(input int r, input int v);
    int lv[3];
    int ord[6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};
    int k = r / 6, p = r % 6;
    if (k % 2 == 0) begin
      lv = '{0, 0, 0}; lv[k/2] = 1;
    end else begin
      lv = '{1, 1, 1}; lv[(k == 1) ? 2 : (k == 3) ? 0 : 1] = 0;
    end
    for (int j = 0; j < v; j++) lv[ord[p][j]]++;
    return {2'(lv[2]), 2'(lv[1]), 2'(lv[0])};
  endfunction

  function automatic bit ref_bad(input logic [5:0] x, input logic [5:0] y);
    int n = 0;
    bit big = 0;
    for (int p = 0; p < 3; p++) begin
      int d = int'(x[2*p +: 2]) - int'(y[2*p +: 2]);
      if (d != 0) n++;
      if (d > 1 || d < -1) big = 1;
    end
    return (n > 1) || big;
  endfunction

  function automatic logic [4*DW-1:0] pack_dw(input int t0, t1, t2, t3);
    return {DW'(t3), DW'(t2), DW'(t1), DW'(t0)};
  endfunction

  // drive one command on a falling edge, withdraw it one cycle later
  task automatic send(input int r, input logic [4*DW-1:0] dw);
    cmd_valid = 1'b1; cmd_region = 6'(r); cmd_dwell = dw;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_region = 6'd0; cmd_dwell = '1;
  endtask

  task automatic run_period(input int r, input int t0, t1, t2, t3);
    logic [5:0] el [64];
    logic [2:0] es [64];
    bit ee [64];
    int dur [7];
    int n = 0;
    string tag;
    bit ok_t = 1, ok_e = 1;
    logic [31:0] act = 0, exp = 0, acte = 0, expe = 0;
    dur = '{t0, t1, t2, 2*t3, t2, t1, t0};
    for (int s = 0; s < 7; s++)
      for (int c = 0; c < dur[s]; c++) begin
        el[n] = ref_vec(r, (s <= 3) ? s : 6 - s);
        es[n] = 3'(s);
        ee[n] = (n > 0 && es[n-1] != 3'(s)) ? ref_bad(el[n-1], el[n]) : 1'b0;
        n++;
      end
    tag = (t0 == 0 || t1 == 0 || t2 == 0 || t3 == 0) ? "R7" : "R3";
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R5", "ready before period", 32'(cmd_ready), 1);
    send(r, pack_dw(t0, t1, t2, t3));
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (ok_t && ({lvl_c, lvl_b, lvl_a} != el[i] || seg_idx != es[i])) begin
        ok_t = 0; act = {lvl_c, lvl_b, lvl_a, 5'd0, seg_idx}; exp = {el[i], 5'd0, es[i]};
      end
      if (ok_e && step_err != ee[i]) begin
        ok_e = 0; acte = 32'(step_err); expe = 32'(ee[i]);
      end
    end
    chk(ok_t, tag, $sformatf("trace region %0d (R2 vectors, R4 latch)", r), act, exp);
    chk(ok_e, "R8", $sformatf("step flag region %0d", r), acte, expe);
    @(negedge clk);
    chk({lvl_c, lvl_b, lvl_a} == el[n-1] && seg_idx == es[n-1] && cmd_ready,
        "R9", "hold after period", {lvl_c, lvl_b, lvl_a, seg_idx, cmd_ready},
        {el[n-1], es[n-1], 1'b1});
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [5:0] keep_l;
    logic [2:0] keep_s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({lvl_c, lvl_b, lvl_a} == 6'b010101 && seg_idx == 0 && !step_err && cmd_ready,
        "R1", "reset state", {lvl_c, lvl_b, lvl_a, seg_idx, step_err, cmd_ready},
        {6'b010101, 3'd0, 1'b0, 1'b1});

    for (int e = 0; e < NTAB; e++)
      run_period(TBL[e][0], TBL[e][1], TBL[e][2], TBL[e][3], TBL[e][4]);

    // R6: out-of-range region is dropped
    keep_l = {lvl_c, lvl_b, lvl_a}; keep_s = seg_idx;
    @(negedge clk);
    send(40, pack_dw(1, 1, 1, 1));
    for (int i = 0; i < 2; i++) begin
      chk({lvl_c, lvl_b, lvl_a} == keep_l && seg_idx == keep_s && cmd_ready,
          "R6", "bad region held", {lvl_c, lvl_b, lvl_a, seg_idx}, {keep_l, keep_s});
      @(negedge clk);
    end

    // R10: all-zero dwell
    send(5, pack_dw(0, 0, 0, 0));
    chk({lvl_c, lvl_b, lvl_a} == keep_l && seg_idx == keep_s && cmd_ready,
        "R10", "zero period", {lvl_c, lvl_b, lvl_a, seg_idx}, {keep_l, keep_s});

    // R5: back-to-back periods, region 0 then 2, each 8 cycles long
    @(negedge clk);
    send(0, pack_dw(1, 1, 1, 1));
    repeat (6) @(negedge clk);
    chk(cmd_ready == 1'b0, "R5", "ready low mid period", 32'(cmd_ready), 0);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R5", "ready in last cycle", 32'(cmd_ready), 1);
    send(2, pack_dw(1, 1, 1, 1));
    chk({lvl_c, lvl_b, lvl_a} == ref_vec(2, 0) && seg_idx == 0,
        "R5", "no gap between periods", {lvl_c, lvl_b, lvl_a, seg_idx},
        {ref_vec(2, 0), 3'd0});
    chk(step_err == 1'b0, "R8", "no flag at period start", 32'(step_err), 0);
    repeat (10) @(negedge clk);
    chk({lvl_c, lvl_b, lvl_a} == ref_vec(2, 0) && seg_idx == 6 && cmd_ready,
        "R9", "hold after back-to-back", {lvl_c, lvl_b, lvl_a, seg_idx},
        {ref_vec(2, 0), 3'd6});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule